// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This unit gathers the five interrupt causes of a UART (receive line error, address match, receive data available, transmit holding register empty and transmitter fully idle), keeps each in its own sticky latch, and reports the most urgent enabled cause as a 3-bit code in an identification word. The word carries an active-low "nothing pending" flag in bit 0. A single request line goes high whenever any enabled cause is latched.

Each cause has its own clear rule, tied to register accesses that the surrounding UART decodes and passes in as one-cycle strobes.
- Reading the line status register clears the line error.
- Reading the receive buffer clears the address match and the data-available cause.
- Writing the transmit holding register clears both transmit causes.
- Reading the identification word clears a transmit cause, but only when that cause is the one being reported in that read.

A second copy of the word is offered on a shadow port. Its read strobe has no side effect, so diagnostic software can look at the word without disturbing any cause.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset all latches are clear, `id_o` reads 0x01 and `irq_o` is 0.
- R2: `id_o[0]` is 0 when at least one enabled cause is latched and 1 otherwise. Bits above bit 3 always read 0.
- R3: `id_o[3:1]` carries the code of the highest-priority enabled latched cause. From highest to lowest the codes are: line error 3'b011 (`evt_i[0]`), address match 3'b100 (`evt_i[1]`), data available 3'b010 (`evt_i[2]`), holding empty 3'b001 (`evt_i[3]`) and transmitter idle 3'b000 (`evt_i[4]`). When nothing is pending the code is 3'b000.
- R4: The line error latch is cleared only by `rd_lsr_i`. Other strobes, including `rd_id_i`, leave it set.
- R5: The address match and data available latches are both cleared by `rd_rbr_i`.
- R6: `wr_thr_i` clears both transmit latches.
- R7: When `rd_id_i` is high, the latch of the cause reported in that same cycle is cleared if it is a transmit cause. No other latch is cleared.
- R8: A latch whose event pulse and clear condition arrive in the same cycle ends up set.
- R9: A cause whose bit in `en_i` is 0 does not appear in `id_o` and does not raise `irq_o`, but its latch keeps its state. Raising the enable later reveals it. `irq_o` equals the inverse of `id_o[0]`.
- R10: `shadow_o` always equals `id_o`, and `rd_shadow_i` changes no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 5 | One-cycle event pulses, one bit per cause (bit order as in R3) |
| en_i | input | 5 | Per-cause enable, same bit order |
| rd_id_i | input | 1 | Read strobe of the identification word |
| rd_lsr_i | input | 1 | Read strobe of the line status register |
| rd_rbr_i | input | 1 | Read strobe of the receive buffer |
| wr_thr_i | input | 1 | Write strobe of the transmit holding register |
| rd_shadow_i | input | 1 | Read strobe of the shadow copy (no side effect) |
| id_o | output | REG_W | Identification word |
| shadow_o | output | REG_W | Shadow copy of the identification word |
| irq_o | output | 1 | Interrupt request |

## Verification
The priority encoder is tried three ways: with each cause raised alone, with causes stacked so that each new cause outranks or is outranked by the one already latched, and with both transmit causes pending together. These patterns separate a wrong code from a wrong order.

The clear rules are tried by applying each strobe while causes it must not touch are also latched. The identification read is applied while a non-transmit cause is reported, which shows that the read clears only the reported transmit source. Masking is tested by latching a disabled cause and then enabling it. The set-wins rule is tested by colliding a pulse with its own clear. Repeated shadow reads must leave the word unchanged.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 5;
    localparam int CODE_W  = 3;

    // Source index doubles as priority rank: lower index wins.
    typedef enum logic [2:0] {
        SRC_LINE = 3'd0,
        SRC_ADDR = 3'd1,
        SRC_RXD  = 3'd2,
        SRC_THRE = 3'd3,
        SRC_TEMT = 3'd4
    } irq_src_e;

    typedef enum logic [CODE_W-1:0] {
        CODE_TEMT = 3'b000,
        CODE_THRE = 3'b001,
        CODE_RXD  = 3'b010,
        CODE_LINE = 3'b011,
        CODE_ADDR = 3'b100
    } irq_code_e;

    typedef struct packed {
        logic      pending;
        irq_code_e code;
    } irq_report_t;

    function automatic irq_code_e code_of(input int idx);
        case (idx)
            0:       return CODE_LINE;
            1:       return CODE_ADDR;
            2:       return CODE_RXD;
            3:       return CODE_THRE;
            default: return CODE_TEMT;
        endcase
    endfunction

    function automatic logic is_tx_src(input int idx);
        return (idx == int'(SRC_THRE)) || (idx == int'(SRC_TEMT));
    endfunction

endpackage

// File: rtl/uart_irq_latch.sv
module uart_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    // R8: a pulse always leaves the latch set, even against a clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] lat_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic [NUM_SRC-1:0] grant_o,
    output irq_report_t        rep_o
);
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] higher;   // higher[i]: some cause above i is active

    assign active = lat_i & en_i;

    assign higher[0] = 1'b0;
    for (genvar i = 1; i < NUM_SRC; i++) begin : g_chain
        assign higher[i] = higher[i-1] | active[i-1];
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_grant
        assign grant_o[i] = active[i] & ~higher[i];
    end

    always_comb begin
        rep_o.pending = |active;
        rep_o.code    = CODE_TEMT;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant_o[i]) rep_o.code = code_of(i);
        end
    end

    always_comb begin
        assert_one_grant_R3: assert ($onehot0(grant_o));
        assert_grant_pend_R2: assert ((|grant_o) == rep_o.pending);
    end
endmodule

// File: rtl/uart_irq_clear.sv
module uart_irq_clear
    import uart_irq_pkg::*;
(
    input  logic               rd_id_i,
    input  logic               rd_lsr_i,
    input  logic               rd_rbr_i,
    input  logic               wr_thr_i,
    input  logic [NUM_SRC-1:0] grant_i,
    output logic [NUM_SRC-1:0] clr_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
        if (i == int'(SRC_LINE)) begin : g_line
            assign clr_o[i] = rd_lsr_i;
        end else if (is_tx_src(i)) begin : g_tx
            // Only the cause granted at the read instant is acknowledged.
            assign clr_o[i] = wr_thr_i | (rd_id_i & grant_i[i]);
        end else begin : g_rx
            assign clr_o[i] = rd_rbr_i;
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               rd_id_i,
    input  logic               rd_lsr_i,
    input  logic               rd_rbr_i,
    input  logic               wr_thr_i,
    input  logic               rd_shadow_i,
    output logic [REG_W-1:0]   id_o,
    output logic [REG_W-1:0]   shadow_o,
    output logic               irq_o
);
    localparam int USED_W = CODE_W + 1;
    localparam int PAD_W  = REG_W - USED_W;

    logic [NUM_SRC-1:0] lat;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] grant;
    irq_report_t        rep;
    logic [USED_W-1:0]  low_bits;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        uart_irq_latch u_lat (
            .clk   (clk),
            .rst   (rst),
            .set_i (evt_i[i]),
            .clr_i (clr[i]),
            .q_o   (lat[i])
        );
    end

    uart_irq_prio u_prio (
        .lat_i   (lat),
        .en_i    (en_i),
        .grant_o (grant),
        .rep_o   (rep)
    );

    uart_irq_clear u_clr (
        .rd_id_i  (rd_id_i),
        .rd_lsr_i (rd_lsr_i),
        .rd_rbr_i (rd_rbr_i),
        .wr_thr_i (wr_thr_i),
        .grant_i  (grant),
        .clr_o    (clr)
    );

    assign low_bits = {rep.code, ~rep.pending};

    if (PAD_W > 0) begin : g_pad
        assign id_o = {{PAD_W{1'b0}}, low_bits};
    end else begin : g_nopad
        assign id_o = low_bits[REG_W-1:0];
    end

    // The shadow strobe is deliberately unused: reading the copy has no effect.
    logic shadow_unused;
    assign shadow_unused = rd_shadow_i;
    assign shadow_o      = id_o;
    assign irq_o         = rep.pending;

    // R1: reset leaves every latch empty
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (lat == '0));
    // R4: only a line status read drops the line error
    assert_line_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (lat[SRC_LINE] && !rd_lsr_i) |=> lat[SRC_LINE]);
    // R5: receive buffer read drops both receive causes
    assert_rbr_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_rbr_i && !evt_i[SRC_RXD] && !evt_i[SRC_ADDR])
            |=> (!lat[SRC_RXD] && !lat[SRC_ADDR]));
    // R6: holding register write drops both transmit causes
    assert_thr_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_thr_i && !evt_i[SRC_THRE] && !evt_i[SRC_TEMT])
            |=> (!lat[SRC_THRE] && !lat[SRC_TEMT]));
    // R7: id read keeps a transmit cause that was not the one reported
    assert_id_read_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_id_i && !wr_thr_i && lat[SRC_TEMT] && (rep.code != CODE_TEMT))
            |=> lat[SRC_TEMT]);
    // R7: id read reporting holding-empty clears it
    assert_id_read_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_id_i && rep.pending && (rep.code == CODE_THRE) && !evt_i[SRC_THRE])
            |=> !lat[SRC_THRE]);
    // R10: shadow strobe alone never alters any latch
    assert_shadow_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_shadow_i && !rd_id_i && !rd_lsr_i && !rd_rbr_i && !wr_thr_i
            && (evt_i == '0)) |=> $stable(lat));

    always_comb begin
        // R2: bits above the code are always zero
        assert_upper_zero_R2: assert ((id_o >> USED_W) == '0);
        // R9: request line is the inverse of the idle flag
        assert_irq_flag_R9: assert (irq_o == ~id_o[0]);
    end
endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
    localparam int REG_W = 8;
    localparam int NV    = 19;

    logic             clk = 1'b0;
    logic             rst;
    logic [4:0]       evt, en;
    logic             rd_id, rd_lsr, rd_rbr, wr_thr, rd_sh;
    logic [REG_W-1:0] id, sh;
    logic             irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    uart_irq_ident #(.REG_W(REG_W)) uut (
        .clk(clk), .rst(rst), .evt_i(evt), .en_i(en),
        .rd_id_i(rd_id), .rd_lsr_i(rd_lsr), .rd_rbr_i(rd_rbr),
        .wr_thr_i(wr_thr), .rd_shadow_i(rd_sh),
        .id_o(id), .shadow_o(sh), .irq_o(irq)
    );

    // Vector: evt[5] en[5] {rd_id rd_lsr rd_rbr wr_thr}[4] exp_id[8] exp_irq[1]
    localparam logic [22:0] VEC [NV] = '{
        {5'b10000, 5'b11111, 4'b0000, 8'h00, 1'b1}, // R3 idle code alone
        {5'b01000, 5'b11111, 4'b0000, 8'h02, 1'b1}, // R3 thre outranks temt
        {5'b00000, 5'b11111, 4'b1000, 8'h00, 1'b1}, // R7 read clears thre only
        {5'b00000, 5'b11111, 4'b1000, 8'h01, 1'b0}, // R7 read clears temt
        {5'b00100, 5'b11111, 4'b0000, 8'h04, 1'b1}, // R3 rx data
        {5'b00010, 5'b11111, 4'b0000, 8'h08, 1'b1}, // R3 addr over rx
        {5'b00001, 5'b11111, 4'b0000, 8'h06, 1'b1}, // R3 line over addr
        {5'b00000, 5'b11111, 4'b0010, 8'h06, 1'b1}, // R5 rbr read, line stays
        {5'b00000, 5'b11111, 4'b0100, 8'h01, 1'b0}, // R4 lsr read clears line
        {5'b00100, 5'b11011, 4'b0000, 8'h01, 1'b0}, // R9 masked source hidden
        {5'b00000, 5'b11111, 4'b0000, 8'h04, 1'b1}, // R9 enable reveals it
        {5'b00100, 5'b11111, 4'b0010, 8'h04, 1'b1}, // R8 set beats clear
        {5'b00000, 5'b11111, 4'b0010, 8'h01, 1'b0}, // R5 rbr read clears rx
        {5'b11000, 5'b11111, 4'b0000, 8'h02, 1'b1}, // R3 both tx pending
        {5'b00000, 5'b11111, 4'b0001, 8'h01, 1'b0}, // R6 thr write clears both
        {5'b01001, 5'b11111, 4'b0000, 8'h06, 1'b1}, // R3 line over thre
        {5'b00000, 5'b11111, 4'b1000, 8'h06, 1'b1}, // R4 R7 id read clears nothing
        {5'b00000, 5'b11111, 4'b0100, 8'h02, 1'b1}, // R4 lsr read, thre remains
        {5'b00000, 5'b11111, 4'b1000, 8'h01, 1'b0}  // R7 id read clears thre
    };

    task automatic check(input string req, input logic [REG_W-1:0] exp_id,
                         input logic exp_irq);
        checks++;
        if (id !== exp_id || irq !== exp_irq || sh !== exp_id) begin
            errors++;
            $display("FAIL %s: id=%h shadow=%h irq=%b expected id=%h irq=%b",
                     req, id, sh, irq, exp_id, exp_irq);
        end
    endtask

    task automatic step(input logic [4:0] e, input logic [4:0] m,
                        input logic [3:0] s, input logic shr);
        evt = e; en = m;
        {rd_id, rd_lsr, rd_rbr, wr_thr} = s;
        rd_sh = shr;
        @(posedge clk);
        #1;
        evt = '0; {rd_id, rd_lsr, rd_rbr, wr_thr} = '0; rd_sh = 1'b0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: expired, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; evt = '0; en = '1;
        {rd_id, rd_lsr, rd_rbr, wr_thr, rd_sh} = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 8'h01, 1'b0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][22:18], VEC[k][17:13], VEC[k][12:9], 1'b0);
            check($sformatf("R2/R3 vector %0d", k), VEC[k][8:1], VEC[k][0]);
        end

        // R10: shadow reads leave the reported holding-empty cause intact
        step(5'b01000, 5'b11111, 4'b0000, 1'b0);
        for (int k = 0; k < 3; k++) step(5'b0, 5'b11111, 4'b0000, 1'b1);
        check("R10 shadow read side-effect free", 8'h02, 1'b1);

        // R9: disabling the only cause hides it; latch survives
        step(5'b0, 5'b10111, 4'b0000, 1'b0);
        check("R9 mask hides thre", 8'h01, 1'b0);
        step(5'b0, 5'b11111, 4'b0000, 1'b0);
        check("R9 unmask shows thre", 8'h02, 1'b1);

        // R7: id read while thre masked and temt reported clears temt, not thre
        step(5'b10000, 5'b10111, 4'b1000, 1'b0);
        check("R7 temt set then visible", 8'h00, 1'b1);
        step(5'b0, 5'b10111, 4'b1000, 1'b0);
        check("R7 read clears temt only", 8'h01, 1'b0);
        step(5'b0, 5'b11111, 4'b0000, 1'b0);
        check("R7 thre kept while masked", 8'h02, 1'b1);

        // R1: reset in the middle of activity empties everything
        step(5'b11111, 5'b11111, 4'b0000, 1'b0);
        check("R3 all pending shows line", 8'h06, 1'b1);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        check("R1 mid-run reset", 8'h01, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule